// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block keeps the stack pointer of a small processor core. The pointer is 11 bits wide and is exposed to software as two register-mapped bytes: a low byte holding bits 7:0 and a high byte whose three least significant bits hold bits 10:8. The unit turns one-cycle stack requests from the sequencer into RAM addresses. A store (push) moves the pointer up first and then writes at the new location. A load (pop) reads at the current location and then moves the pointer down. A subroutine call stores two bytes and a return loads two bytes, each over two consecutive cycles.

Register writes arrive as a strobe with an address and data byte. They replace one byte of the pointer and take precedence over any stack step in the same cycle. Register reads return the selected byte one cycle later. The stack RAM, the sequencer and any overflow detection live outside this block. The unit only supplies the pointer value and, one cycle after each accepted step, a registered access address with a store/load flag.

Top module: `stkptr_unit`

## Requirements
- R1: Synchronous active-high reset sets the pointer to 0x007, clears `acc_vld_o`, and sets `acc_addr_o` and `rd_data_o` to 0.
- R2: An accepted push raises the pointer by one. On the next cycle it shows `acc_vld_o`=1, `acc_wr_o`=1 and `acc_addr_o` equal to the new pointer, so the first push after reset stores at 0x008.
- R3: An accepted pop shows `acc_vld_o`=1, `acc_wr_o`=0 and `acc_addr_o` equal to the pointer value before the step, and the pointer is lowered by one.
- R4: Steps wrap modulo 2048 across all 11 bits. 0x0FF+1 gives 0x100, 0x100-1 gives 0x0FF, 0x7FF+1 gives 0x000, and 0x000-1 gives 0x7FF.
- R5: A register write to address 0x81 replaces pointer bits 7:0 with the data byte. A write to address 0xB7 replaces bits 10:8 with data bits 2:0. The other byte is left unchanged, and writes to any other address leave the pointer alone.
- R6: A read presents, on `rd_data_o` one cycle later, the selected byte of the pointer as it stood before that cycle's update. Address 0x81 returns bits 7:0. Address 0xB7 returns bits 10:8 in bits 2:0, with bits 7:3 as zero. Any other address returns 0.
- R7: When a write to 0x81 or 0xB7 occurs in the same cycle as a stack step, the write is applied and the step is dropped, with no access issued on the next cycle.
- R8: A call issues two stores in consecutive cycles, at pointer+1 and pointer+2, leaving the pointer raised by two. Any push, pop, call or return request during the second cycle is ignored.
- R9: A return issues two loads in consecutive cycles, at the pointer and at pointer-1, leaving the pointer lowered by two. Any request during the second cycle is ignored.
- R10: When several requests arrive in one idle cycle, only one is accepted, with priority call, then push, then return, then pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Store one byte on the stack |
| pop_i | input | 1 | Load one byte from the stack |
| call_i | input | 1 | Start a two-byte store |
| ret_i | input | 1 | Start a two-byte load |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Registered read data |
| sp_o | output | 11 | Current pointer value |
| acc_vld_o | output | 1 | A stack access is issued this cycle |
| acc_wr_o | output | 1 | 1 for store, 0 for load |
| acc_addr_o | output | 11 | Stack RAM address of the access |

## Verification
A corrupted pointer shows up at `sp_o` on the very clock edge after the faulty update. It also shows up in the next access address, so a mistaken carry or borrow at the byte boundary is visible within one cycle. A lost or stale second-beat flag shows as a missing or extra access, and a pointer off by one, one cycle after a call or return begins. Read data that was sampled after the update, rather than before it, differs from the expected value in the cycle right after any read that coincides with a step.

// File: rtl/stkptr_pkg.sv
`timescale 1ns/1ps
package stkptr_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } stk_step_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_CALL = 2'd1,
    PEND_RET  = 2'd2
  } stk_pend_e;

endpackage

// File: rtl/stkptr_step_arb.sv
`timescale 1ns/1ps
module stkptr_step_arb
  import stkptr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      push_i,
  input  logic      pop_i,
  input  logic      call_i,
  input  logic      ret_i,
  input  logic      wr_hit_i,
  output stk_step_e step_o
);

  stk_pend_e pend_q;
  stk_pend_e pend_d;

  // Second beat of call/return owns its cycle; a register write cancels it.
  always_comb begin
    step_o = STEP_NONE;
    pend_d = PEND_NONE;
    if (pend_q != PEND_NONE) begin
      if (!wr_hit_i)
        step_o = (pend_q == PEND_CALL) ? STEP_INC : STEP_DEC;
    end else if (!wr_hit_i) begin
      if (call_i) begin
        step_o = STEP_INC;
        pend_d = PEND_CALL;
      end else if (push_i) begin
        step_o = STEP_INC;
      end else if (ret_i) begin
        step_o = STEP_DEC;
        pend_d = PEND_RET;
      end else if (pop_i) begin
        step_o = STEP_DEC;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= PEND_NONE;
    else     pend_q <= pend_d;
  end

endmodule

// File: rtl/stkptr_core.sv
`timescale 1ns/1ps
module stkptr_core
  import stkptr_pkg::*;
#(
  parameter int          SP_W    = 11,
  parameter int          DATA_W  = 8,
  parameter logic [10:0] RST_VAL = 11'h007
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_step_e         step_i,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [SP_W-1:0]   sp_o,
  output logic              acc_vld_o,
  output logic              acc_wr_o,
  output logic [SP_W-1:0]   acc_addr_o
);

  localparam int HI_W = SP_W - DATA_W;

  logic [SP_W-1:0] sp_inc;
  logic [SP_W-1:0] sp_dec;
  logic [SP_W-1:0] sp_d;

  assign sp_inc = sp_o + 1'b1;
  assign sp_dec = sp_o - 1'b1;

  always_comb begin
    sp_d = sp_o;
    if (lo_wr_i || hi_wr_i) begin
      if (lo_wr_i) sp_d[DATA_W-1:0]    = wr_data_i;
      if (hi_wr_i) sp_d[SP_W-1:DATA_W] = wr_data_i[HI_W-1:0];
    end else begin
      case (step_i)
        STEP_INC: sp_d = sp_inc;
        STEP_DEC: sp_d = sp_dec;
        default:  sp_d = sp_o;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_o       <= RST_VAL[SP_W-1:0];
      acc_vld_o  <= 1'b0;
      acc_wr_o   <= 1'b0;
      acc_addr_o <= '0;
    end else begin
      sp_o      <= sp_d;
      acc_vld_o <= 1'b0;
      if (!(lo_wr_i || hi_wr_i)) begin
        if (step_i == STEP_INC) begin
          acc_vld_o  <= 1'b1;
          acc_wr_o   <= 1'b1;
          acc_addr_o <= sp_inc;
        end else if (step_i == STEP_DEC) begin
          acc_vld_o  <= 1'b1;
          acc_wr_o   <= 1'b0;
          acc_addr_o <= sp_o;
        end
      end
    end
  end

endmodule

// File: rtl/stkptr_rd_port.sv
`timescale 1ns/1ps
module stkptr_rd_port #(
  parameter int              SP_W    = 11,
  parameter int              DATA_W  = 8,
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h81,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'hB7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [SP_W-1:0]   sp_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int HI_W = SP_W - DATA_W;

  logic [DATA_W-1:0] rd_d;

  always_comb begin
    if (rd_addr_i == LO_ADDR)
      rd_d = sp_i[DATA_W-1:0];
    else if (rd_addr_i == HI_ADDR)
      rd_d = {{(DATA_W-HI_W){1'b0}}, sp_i[SP_W-1:DATA_W]};
    else
      rd_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_d;
  end

endmodule

// File: rtl/stkptr_unit.sv
`timescale 1ns/1ps
module stkptr_unit
  import stkptr_pkg::*;
#(
  parameter int                SP_W    = 11,
  parameter int                DATA_W  = 8,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h81,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'hB7,
  parameter logic [10:0]       RST_VAL = 11'h007
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              acc_vld_o,
  output logic              acc_wr_o,
  output logic [SP_W-1:0]   acc_addr_o
);

  logic      lo_wr;
  logic      hi_wr;
  stk_step_e step;

  assign lo_wr = wr_en_i && (wr_addr_i == LO_ADDR);
  assign hi_wr = wr_en_i && (wr_addr_i == HI_ADDR);

  stkptr_step_arb u_arb (
    .clk      (clk),
    .rst      (rst),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .wr_hit_i (lo_wr || hi_wr),
    .step_o   (step)
  );

  stkptr_core #(
    .SP_W    (SP_W),
    .DATA_W  (DATA_W),
    .RST_VAL (RST_VAL)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step),
    .lo_wr_i    (lo_wr),
    .hi_wr_i    (hi_wr),
    .wr_data_i  (wr_data_i),
    .sp_o       (sp_o),
    .acc_vld_o  (acc_vld_o),
    .acc_wr_o   (acc_wr_o),
    .acc_addr_o (acc_addr_o)
  );

  stkptr_rd_port #(
    .SP_W    (SP_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_addr_i (rd_addr_i),
    .sp_i      (sp_o),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/stkptr_unit_chk.sv
`timescale 1ns/1ps
module stkptr_unit_chk #(
  parameter int                SP_W    = 11,
  parameter int                DATA_W  = 8,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h81,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'hB7,
  parameter logic [10:0]       RST_VAL = 11'h007
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [SP_W-1:0]   sp_o,
  input logic              acc_vld_o,
  input logic              acc_wr_o,
  input logic [SP_W-1:0]   acc_addr_o
);

  localparam int HI_W = SP_W - DATA_W;

  logic wr_hit;
  logic hi_hit;
  assign hi_hit = wr_en_i && (wr_addr_i == HI_ADDR);
  assign wr_hit = hi_hit || (wr_en_i && (wr_addr_i == LO_ADDR));

  AST_RESET_VALUE: assert property (@(posedge clk)
    $past(rst) |-> (sp_o == RST_VAL[SP_W-1:0] && !acc_vld_o)); // R1

  AST_STORE_AT_NEW_SP: assert property (@(posedge clk) disable iff (rst)
    (acc_vld_o && acc_wr_o) |-> (acc_addr_o == sp_o)); // R2

  AST_LOAD_ABOVE_SP: assert property (@(posedge clk) disable iff (rst)
    (acc_vld_o && !acc_wr_o) |-> (acc_addr_o == sp_o + 1'b1)); // R3

  AST_HI_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(hi_hit)) |-> (sp_o[SP_W-1:DATA_W] == $past(wr_data_i[HI_W-1:0]))); // R5

  AST_HI_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd_addr_i == HI_ADDR)) |-> (rd_data_o[DATA_W-1:HI_W] == '0)); // R6

  AST_WRITE_BLOCKS_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_hit)) |-> !acc_vld_o); // R7

  AST_SP_MOVES_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(wr_hit)) |->
      (sp_o == $past(sp_o) || sp_o == $past(sp_o) + 1'b1 || sp_o == $past(sp_o) - 1'b1)); // R4

endmodule

bind stkptr_unit stkptr_unit_chk #(
  .SP_W    (SP_W),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .LO_ADDR (LO_ADDR),
  .HI_ADDR (HI_ADDR),
  .RST_VAL (RST_VAL)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .sp_o       (sp_o),
  .acc_vld_o  (acc_vld_o),
  .acc_wr_o   (acc_wr_o),
  .acc_addr_o (acc_addr_o)
);

// File: tb/test_stkptr_unit.sv
`timescale 1ns/1ps
module test_stkptr_unit;

  localparam int CLK_PERIOD = 10;
  localparam int LO_A = 8'h81;
  localparam int HI_A = 8'hB7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_i = 0, pop_i = 0, call_i = 0, ret_i = 0, wr_en_i = 0;
  logic [7:0] wr_addr_i = 0, wr_data_i = 0, rd_addr_i = 0;
  logic [7:0] rd_data_o;
  logic [10:0] sp_o, acc_addr_o;
  logic       acc_vld_o, acc_wr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference state
  int m_sp, m_pend, m_vld, m_wr, m_addr, m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  stkptr_unit i_stkptr_unit (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .call_i(call_i),
    .ret_i(ret_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .sp_o(sp_o), .acc_vld_o(acc_vld_o), .acc_wr_o(acc_wr_o),
    .acc_addr_o(acc_addr_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_update();
    int step, hit;
    if (rst) begin
      m_sp = 7; m_pend = 0; m_vld = 0; m_wr = 0; m_addr = 0; m_rd = 0;
      return;
    end
    hit = wr_en_i && (wr_addr_i == LO_A || wr_addr_i == HI_A);
    if (rd_addr_i == LO_A)      m_rd = m_sp % 256;
    else if (rd_addr_i == HI_A) m_rd = m_sp / 256;
    else                        m_rd = 0;
    step = 0;
    if (m_pend != 0) begin
      if (!hit) step = (m_pend == 1) ? 1 : -1;
      m_pend = 0;
    end else if (!hit) begin
      if (call_i)     begin step = 1;  m_pend = 1; end
      else if (push_i) step = 1;
      else if (ret_i) begin step = -1; m_pend = 2; end
      else if (pop_i)  step = -1;
    end
    m_vld = 0;
    if (hit) begin
      if (wr_addr_i == LO_A) m_sp = (m_sp / 256) * 256 + wr_data_i;
      else                   m_sp = (m_sp % 256) + (wr_data_i % 8) * 256;
    end else if (step == 1) begin
      m_sp = (m_sp + 1) % 2048; m_vld = 1; m_wr = 1; m_addr = m_sp;
    end else if (step == -1) begin
      m_vld = 1; m_wr = 0; m_addr = m_sp; m_sp = (m_sp + 2047) % 2048;
    end
  endtask

  task automatic compare();
    chk(tag, "sp_o", int'(sp_o), m_sp);
    chk(tag, "acc_vld_o", int'(acc_vld_o), m_vld);
    if (m_vld != 0) begin
      chk(tag, "acc_wr_o", int'(acc_wr_o), m_wr);
      chk(tag, "acc_addr_o", int'(acc_addr_o), m_addr);
    end
    chk(tag, "rd_data_o", int'(rd_data_o), m_rd);
  endtask

  task automatic cyc(input bit pu, input bit po, input bit ca, input bit re,
                     input bit we, input int wa, input int wd, input int ra);
    push_i = pu; pop_i = po; call_i = ca; ret_i = re;
    wr_en_i = we; wr_addr_i = 8'(wa); wr_data_i = 8'(wd); rd_addr_i = 8'(ra);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int ra);
    cyc(0, 0, 0, 0, 0, 0, 0, ra);
  endtask

  task automatic wr(input int a, input int d);
    cyc(0, 0, 0, 0, 1, a, d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    @(negedge clk);
    rst = 1;
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    rst = 0;
    // R1: reset value checked directly
    tag = "R1";
    chk("R1", "sp_o after reset", int'(sp_o), 'h007);
    chk("R1", "acc_vld_o after reset", int'(acc_vld_o), 0);
    idle(LO_A);
    chk("R1", "read low byte after reset", int'(rd_data_o), 'h07);

    // R2: first push lands at 0x008
    tag = "R2";
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2", "first push address", int'(acc_addr_o), 'h008);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, LO_A);
    idle(0);

    // R3: pops read before moving down
    tag = "R3";
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R3", "pop address", int'(acc_addr_o), 'h00A);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    idle(0);

    // R5 and R4: carry/borrow at byte edge, wrap at top and bottom
    tag = "R5";
    wr(LO_A, 'hFF);
    chk("R5", "low byte write", int'(sp_o), 'h0FF);
    tag = "R4";
    cyc(1, 0, 0, 0, 0, 0, 0, HI_A);
    chk("R4", "carry into high byte", int'(sp_o), 'h100);
    cyc(0, 1, 0, 0, 0, 0, 0, HI_A);
    chk("R4", "borrow from high byte", int'(sp_o), 'h0FF);
    tag = "R5";
    wr(HI_A, 'hFF);
    chk("R5", "high write keeps low byte", int'(sp_o), 'h7FF);
    tag = "R4";
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", "wrap 0x7FF to 0x000", int'(sp_o), 'h000);
    chk("R4", "store address after wrap", int'(acc_addr_o), 'h000);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R4", "wrap 0x000 to 0x7FF", int'(sp_o), 'h7FF);

    // R6: read of high byte masks bits 7:3, other addresses read zero
    tag = "R6";
    idle(HI_A);
    chk("R6", "high byte read", int'(rd_data_o), 'h07);
    idle(8'h20);
    chk("R6", "unmapped read", int'(rd_data_o), 0);
    wr(8'h20, 'h55);
    chk("R5", "unmapped write ignored", int'(sp_o), 'h7FF);
    cyc(1, 0, 0, 0, 0, 0, 0, LO_A);
    chk("R6", "read shows value before step", int'(rd_data_o), 'hFF);

    // R7: write beats a same-cycle step
    tag = "R7";
    wr(HI_A, 0); wr(LO_A, 'h40);
    cyc(1, 0, 0, 0, 1, LO_A, 'h10, 0);
    chk("R7", "write wins over push", int'(sp_o), 'h010);
    chk("R7", "no access on collision", int'(acc_vld_o), 0);
    cyc(0, 1, 0, 0, 1, HI_A, 'h02, 0);
    chk("R7", "write wins over pop", int'(sp_o), 'h210);

    // R8: call stores two bytes
    tag = "R8";
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R8", "call beat 1 address", int'(acc_addr_o), 'h211);
    cyc(1, 1, 1, 1, 0, 0, 0, 0);
    chk("R8", "call beat 2 address", int'(acc_addr_o), 'h212);
    chk("R8", "sp after call", int'(sp_o), 'h212);
    idle(0);
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, LO_A, 'h33, 0);
    chk("R7", "write cancels call beat 2", int'(sp_o), 'h233);

    // R9: return loads two bytes
    tag = "R9";
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R9", "ret beat 1 address", int'(acc_addr_o), 'h233);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R9", "ret beat 2 address", int'(acc_addr_o), 'h232);
    chk("R9", "sp after ret", int'(sp_o), 'h231);

    // R10: priority among same-cycle requests
    tag = "R10";
    idle(0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0);
    chk("R10", "push beats pop", int'(acc_wr_o), 1);
    cyc(0, 1, 0, 1, 0, 0, 0, 0);
    chk("R10", "ret beats pop", int'(sp_o), 'h231);
    idle(0);
    cyc(1, 0, 1, 0, 0, 0, 0, 0);
    idle(0);
    chk("R10", "call beats push", int'(sp_o), 'h232);

    // Mixed traffic against the reference model
    r = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      int wa;
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      wa = (r[9:8] == 2'd0) ? LO_A : (r[9:8] == 2'd1) ? HI_A : 8'h20;
      cyc(r[0], r[1], r[2] & r[3], r[4] & r[5], r[6] & r[7],
          wa, int'(r[23:16]), (r[25:24] == 2'd0) ? LO_A : HI_A);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule